// File: doc/BRIEF.md
# Power-Up Record Restore Scanner

After reset this block rebuilds the contents of an emulated non-volatile RAM window from a log of 32-bit backup records held in a sectored flash array. It first samples its configuration: how many halfwords the window has and how many backup sectors are in use. It then fills every window halfword with the erased value. Next it reads one header word per sector to find which sectors are in use and which of them is oldest. Finally it walks the records of the in-use sectors from oldest to newest. Each complete record writes its 16-bit value into the RAM image, so the last complete record seen for an address is the value that survives.

A record that power loss left half-programmed is counted as torn and skipped, so the address keeps the previous good value. The block reports how many torn records it found and where the next free backup slot is, so that a separate write engine can append new records. It raises `ready` once the scan is complete. After that it issues no further reads or image writes until the next reset.

Top module: `rec_restore`

## Requirements
- R1: `cfg_win_words` and `cfg_sect_cnt` are sampled once, on the first clock edge after reset is released. Later changes to them have no effect until the next reset.
- R2: Before any backup read, image addresses 0 to `cfg_win_words`-1 are written with 16'hFFFF. A window halfword that no complete record addresses therefore ends at all ones. A window size of 0 produces no image writes at all.
- R3: Slot 0 of each sector holds its header. All ones marks the sector as unused. Otherwise bits [7:0] are its sequence number. Only sectors below `cfg_sect_cnt` are considered. The oldest sector has the smallest sequence number, and on a tie the lowest index wins. Scanning starts at the oldest sector and proceeds in ascending index order, wrapping modulo `cfg_sect_cnt`. Unused sectors are skipped without reads.
- R4: A record has bit 31 as its complete flag (1 = complete), bits [18:16] as the halfword address, bits [30:19] as zero and bits [15:0] as data. Every complete in-window record is written to the image, so a record scanned later overrides an earlier one for the same address.
- R5: Records start at slot 1. A slot reading all ones ends that sector's scan, and the slots after it are neither read nor used.
- R6: A slot that is not all ones but has bit 31 clear is torn. It is not written to the image, the previously restored value for its address stays, and `torn_cnt` increments once for it.
- R7: A complete record whose address is not below `cfg_win_words` does not write the image.
- R8: `free_ptr`, encoded as sector*8+slot, gives the first all-ones slot of the last in-use sector scanned. If that sector is full, it gives slot 1 of the next sector modulo `cfg_sect_cnt`. If no sector is in use, it reads 1.
- R9: `ready` is low until the scan ends and rises on the cycle after the scan's last step. When that last step is a record write, `ready` rises exactly one cycle after that write. From then on `ready` stays high, and neither `img_we` nor `bk_re` asserts.
- R10: The backup read port has a latency of one cycle. There is one read per header and one read per record slot visited, up to and including the slot that ends the sector, with no other reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_win_words | input | AW+1 | Window size in halfwords |
| cfg_sect_cnt | input | SECT_W+1 | Number of backup sectors in use |
| bk_re | output | 1 | Backup array read enable |
| bk_addr | output | SECT_W+SLOT_W | Backup word address, sector*slots+slot |
| bk_rdata | input | 32 | Backup read data, valid the cycle after `bk_re` |
| img_we | output | 1 | RAM image write enable |
| img_addr | output | AW | RAM image halfword address |
| img_wdata | output | 16 | RAM image write data |
| ready | output | 1 | Restore finished |
| torn_cnt | output | SECT_W+SLOT_W | Count of torn records found |
| free_ptr | output | SECT_W+SLOT_W | Next free backup slot |

## Verification
The bench targets several orderings. It uses a wrapped log whose oldest sector is not sector 0, and two sectors with equal sequence numbers. A design that scanned in plain index order, or that broke ties the wrong way, would restore a stale value for the shared addresses. It places torn records after good ones for the same address. A design that restored them, or that cleared the address, would show a corrupt or erased halfword. It places valid-looking records beyond an erased slot, beyond the window, and in sectors above the configured count, so that a scan that failed to stop or filter would overwrite image data. It also checks the timing of `ready` against the final write of a full newest sector, and changes the configuration just after reset to show that it is not sampled again.

// File: rtl/rec_restore_pkg.sv
package rec_restore_pkg;

   typedef enum logic [2:0] {
      ST_CFG,
      ST_FILL,
      ST_HDR,
      ST_SCAN,
      ST_DONE
   } scan_st_e;

   localparam int REC_W    = 32;
   localparam int HALF_W   = 16;
   localparam int DONE_BIT = 31;

endpackage

// File: rtl/rec_restore_dec.sv
module rec_restore_dec
   import rec_restore_pkg::*;
#(
   parameter int AW = 3
) (
   input  logic [REC_W-1:0]  word,
   input  logic [AW:0]       win,
   output logic              erased,
   output logic              torn,
   output logic              hit,
   output logic [AW-1:0]     addr,
   output logic [HALF_W-1:0] data
);

   if (AW < 1 || AW > 15) begin : g_bad_aw
      $error("rec_restore_dec: AW must lie in 1..15");
   end

   always_comb begin
      erased = &word;
      addr   = word[HALF_W +: AW];
      data   = word[HALF_W-1:0];
      torn   = !erased && !word[DONE_BIT];
      hit    = !erased && word[DONE_BIT] && ({1'b0, addr} < win);
   end

endmodule

// File: rtl/rec_restore_hdr.sv
module rec_restore_hdr
   import rec_restore_pkg::*;
#(
   parameter int SECT_W = 2,
   parameter int SEQ_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hv,
   input  logic [SECT_W-1:0]  hsect,
   input  logic [REC_W-1:0]   hword,
   output logic [(1<<SECT_W)-1:0] act,
   output logic [SECT_W-1:0]  oldest
);

   localparam int NSECT = 1 << SECT_W;

   if (SEQ_W < 1 || SEQ_W > REC_W - 1) begin : g_bad_seq
      $error("rec_restore_hdr: SEQ_W out of range");
   end

   logic             live;
   logic             any_act;
   logic [SEQ_W-1:0] best_q;

   assign live    = hv && !(&hword);
   assign any_act = |act;

   for (genvar g = 0; g < NSECT; g++) begin : g_act
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                  act[g] <= 1'b0;
         else if (live && (hsect == SECT_W'(g)))      act[g] <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         best_q <= '0;
         oldest <= '0;
      end else if (live && (!any_act || (hword[SEQ_W-1:0] < best_q))) begin
         best_q <= hword[SEQ_W-1:0];
         oldest <= hsect;
      end
   end

   // R3: the chosen oldest sector is always one that is in use
   p_oldest_live_r3: assert property (@(posedge clk) disable iff (!rst_n)
      any_act |-> act[oldest]);

endmodule

// File: rtl/rec_restore.sv
module rec_restore
   import rec_restore_pkg::*;
#(
   parameter int SECT_W = 2,
   parameter int SLOT_W = 3,
   parameter int AW     = 3,
   parameter int SEQ_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [AW:0]               cfg_win_words,
   input  logic [SECT_W:0]           cfg_sect_cnt,
   output logic                      bk_re,
   output logic [SECT_W+SLOT_W-1:0]  bk_addr,
   input  logic [31:0]               bk_rdata,
   output logic                      img_we,
   output logic [AW-1:0]             img_addr,
   output logic [15:0]               img_wdata,
   output logic                      ready,
   output logic [SECT_W+SLOT_W-1:0]  torn_cnt,
   output logic [SECT_W+SLOT_W-1:0]  free_ptr
);

   localparam int NSECT = 1 << SECT_W;
   localparam int BA_W  = SECT_W + SLOT_W;

   if (SECT_W < 1 || SLOT_W < 1) begin : g_bad_geom
      $error("rec_restore: SECT_W and SLOT_W must be at least 1");
   end
   if (HALF_W + AW + 1 > REC_W) begin : g_bad_fit
      $error("rec_restore: address field does not fit the record");
   end

   scan_st_e          state_q;
   logic [AW:0]       win_q;
   logic [SECT_W:0]   ns_q;
   logic [AW:0]       fcnt_q;
   logic [SECT_W:0]   hcnt_q;
   logic              rv_q;
   logic [SECT_W-1:0] rsect_q;
   logic [SLOT_W-1:0] rslot_q;
   logic [SECT_W-1:0] cur_q;
   logic [SECT_W:0]   scnt_q;
   logic [SLOT_W:0]   iss_q;
   logic [BA_W-1:0]   torn_q;
   logic [BA_W-1:0]   free_q;

   logic              d_erased, d_torn, d_hit;
   logic [AW-1:0]     d_addr;
   logic [HALF_W-1:0] d_data;
   logic [NSECT-1:0]  act;
   logic [SECT_W-1:0] oldest;

   logic in_fill, fill_we, hdr_iss, hv, scan_rv, act_cur;
   logic hit_end, skip, adv, scan_iss, scan_we, last_sect;
   logic [SECT_W-1:0] nxt_sect;

   rec_restore_dec #(.AW(AW)) u_dec (
      .word   (bk_rdata),
      .win    (win_q),
      .erased (d_erased),
      .torn   (d_torn),
      .hit    (d_hit),
      .addr   (d_addr),
      .data   (d_data)
   );

   rec_restore_hdr #(.SECT_W(SECT_W), .SEQ_W(SEQ_W)) u_hdr (
      .clk    (clk),
      .rst_n  (rst_n),
      .hv     (hv),
      .hsect  (rsect_q),
      .hword  (bk_rdata),
      .act    (act),
      .oldest (oldest)
   );

   always_comb begin
      in_fill   = (state_q == ST_FILL);
      fill_we   = in_fill && (fcnt_q < win_q);
      hdr_iss   = (state_q == ST_HDR) && (hcnt_q < ns_q);
      hv        = (state_q == ST_HDR) && rv_q;
      act_cur   = act[cur_q];
      scan_rv   = (state_q == ST_SCAN) && rv_q;
      hit_end   = scan_rv && (d_erased || (&rslot_q));
      skip      = (state_q == ST_SCAN) && !act_cur;
      adv       = hit_end || skip;
      scan_iss  = (state_q == ST_SCAN) && act_cur && !hit_end && !iss_q[SLOT_W];
      scan_we   = scan_rv && d_hit;
      last_sect = (scnt_q == ns_q - 1'b1);
      nxt_sect  = ({1'b0, cur_q} == ns_q - 1'b1) ? '0 : cur_q + 1'b1;

      bk_re     = hdr_iss || scan_iss;
      bk_addr   = (state_q == ST_HDR) ? {hcnt_q[SECT_W-1:0], {SLOT_W{1'b0}}}
                                      : {cur_q, iss_q[SLOT_W-1:0]};
      img_we    = fill_we || scan_we;
      img_addr  = in_fill ? fcnt_q[AW-1:0] : d_addr;
      img_wdata = in_fill ? '1 : d_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_CFG;
         win_q   <= '0;
         ns_q    <= '0;
         fcnt_q  <= '0;
         hcnt_q  <= '0;
         rv_q    <= 1'b0;
         rsect_q <= '0;
         rslot_q <= '0;
         cur_q   <= '0;
         scnt_q  <= '0;
         iss_q   <= (SLOT_W+1)'(1);
         torn_q  <= '0;
         free_q  <= BA_W'(1);
      end else begin
         unique case (state_q)
            ST_CFG: begin
               win_q   <= cfg_win_words;
               ns_q    <= cfg_sect_cnt;
               fcnt_q  <= '0;
               state_q <= ST_FILL;
            end
            ST_FILL: begin
               if (fill_we) fcnt_q <= fcnt_q + 1'b1;
               if (fcnt_q + 1'b1 >= win_q) begin
                  hcnt_q  <= '0;
                  state_q <= ST_HDR;
               end
            end
            ST_HDR: begin
               rv_q    <= hdr_iss;
               rsect_q <= hcnt_q[SECT_W-1:0];
               if (hdr_iss) hcnt_q <= hcnt_q + 1'b1;
               if ((hcnt_q == ns_q) && !rv_q) begin
                  cur_q   <= oldest;
                  scnt_q  <= '0;
                  iss_q   <= (SLOT_W+1)'(1);
                  state_q <= (ns_q == '0) ? ST_DONE : ST_SCAN;
               end
            end
            ST_SCAN: begin
               rv_q    <= scan_iss;
               rslot_q <= iss_q[SLOT_W-1:0];
               if (scan_iss) iss_q <= iss_q + 1'b1;
               if (scan_rv && d_torn) torn_q <= torn_q + 1'b1;
               if (hit_end)
                  free_q <= d_erased ? {cur_q, rslot_q} : {nxt_sect, SLOT_W'(1)};
               if (adv) begin
                  if (last_sect) begin
                     state_q <= ST_DONE;
                  end else begin
                     cur_q  <= nxt_sect;
                     scnt_q <= scnt_q + 1'b1;
                     iss_q  <= (SLOT_W+1)'(1);
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign ready    = (state_q == ST_DONE);
   assign torn_cnt = torn_q;
   assign free_ptr = free_q;

   // R1: configuration never moves once captured
   p_cfg_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_CFG) |=> ($stable(win_q) && $stable(ns_q)));

   // R3: reads only touch configured sectors
   p_read_in_part_r3: assert property (@(posedge clk) disable iff (!rst_n)
      bk_re |-> ({1'b0, bk_addr[BA_W-1:SLOT_W]} < ns_q));

   // R6: a torn record never reaches the image
   p_torn_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (scan_rv && d_torn) |-> !img_we);

   // R6: torn count only grows
   p_torn_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(torn_q) <= torn_q);

   // R9: silent once ready
   p_quiet_after_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (!img_we && !bk_re));

   // R9: ready is sticky
   p_ready_holds_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

endmodule

// File: tb/tb_rec_restore.sv
`timescale 1ns/1ps
module tb_rec_restore;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  cfg_win_words = '0;
   logic [2:0]  cfg_sect_cnt = '0;
   logic        bk_re;
   logic [4:0]  bk_addr;
   logic [31:0] bk_rdata = '1;
   logic        img_we;
   logic [2:0]  img_addr;
   logic [15:0] img_wdata;
   logic        ready;
   logic [4:0]  torn_cnt;
   logic [4:0]  free_ptr;

   always #2.5 clk = ~clk;

   rec_restore dut (
      .clk(clk), .rst_n(rst_n), .cfg_win_words(cfg_win_words),
      .cfg_sect_cnt(cfg_sect_cnt), .bk_re(bk_re), .bk_addr(bk_addr),
      .bk_rdata(bk_rdata), .img_we(img_we), .img_addr(img_addr),
      .img_wdata(img_wdata), .ready(ready), .torn_cnt(torn_cnt),
      .free_ptr(free_ptr)
   );

   logic [31:0] bmem [32];
   logic [15:0] img [8];
   logic [15:0] exp_img [8];
   int exp_torn, exp_free, exp_reads;
   int n_run = 0, n_fail = 0;
   int cyc = 0, reads = 0, late = 0, last_we = -1, rdy_cyc = -1;
   bit seen_rdy = 0;
   logic [31:0] rs = 32'h1234_5678;

   always @(posedge clk) if (bk_re) bk_rdata <= bmem[bk_addr];

   always @(posedge clk) begin
      cyc++;
      if (rst_n) begin
         if (bk_re) reads++;
         if ((bk_re || img_we) && ready) late++;
         if (img_we) begin
            img[img_addr] = img_wdata;
            last_we = cyc;
         end
         if (ready && !seen_rdy) begin
            seen_rdy = 1;
            rdy_cyc = cyc;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   function automatic logic [31:0] rnd();
      rs = rs ^ (rs << 13);
      rs = rs ^ (rs >> 17);
      rs = rs ^ (rs << 5);
      return rs;
   endfunction

   function automatic logic [31:0] mk_rec(input int a, input logic [15:0] d);
      return {1'b1, 12'd0, 3'(a), d};
   endfunction
   function automatic logic [31:0] mk_torn(input int a, input logic [15:0] d);
      return {1'b0, 12'd0, 3'(a), d};
   endfunction
   function automatic logic [31:0] mk_hdr(input int s);
      return {24'd0, 8'(s)};
   endfunction

   task automatic wipe();
      for (int i = 0; i < 32; i++) bmem[i] = '1;
   endtask

   // reference model built from R2..R8, R10
   task automatic model(input int ns, input int win);
      int old, best;
      bit found, ended;
      logic [31:0] d;
      old = 0; best = 0; found = 0;
      for (int a = 0; a < 8; a++) exp_img[a] = (a < win) ? 16'hFFFF : 16'h5A5A;
      exp_torn = 0; exp_free = 1; exp_reads = ns;
      for (int i = 0; i < ns; i++) begin
         d = bmem[i*8];
         if (d != '1 && (!found || int'(d[7:0]) < best)) begin
            found = 1; best = int'(d[7:0]); old = i;
         end
      end
      for (int k = 0; k < ns; k++) begin
         int s;
         s = (old + k) % ns;
         if (bmem[s*8] != '1) begin
            ended = 0;
            for (int sl = 1; sl < 8; sl++) begin
               exp_reads++;
               d = bmem[s*8+sl];
               if (d == '1) begin
                  exp_free = s*8 + sl; ended = 1; break;
               end else if (!d[31]) exp_torn++;
               else if (int'(d[18:16]) < win) exp_img[d[18:16]] = d[15:0];
            end
            if (!ended) exp_free = ((s + 1) % ns)*8 + 1;
         end
      end
   endtask

   task automatic run_case(input int ns, input int win, input bit twist);
      int t;
      rst_n = 1'b0;
      cfg_win_words = 4'(win);
      cfg_sect_cnt = 3'(ns);
      for (int a = 0; a < 8; a++) img[a] = 16'h5A5A;
      repeat (2) @(negedge clk);
      reads = 0; late = 0; last_we = -1; rdy_cyc = -1; seen_rdy = 0;
      chk("R9 ready low in reset", {31'd0, ready}, 32'd0);
      rst_n = 1'b1;
      if (twist) begin
         @(negedge clk);
         cfg_win_words = 4'd2;
         cfg_sect_cnt = 3'd4;
      end
      t = 0;
      while (!ready && t < 3000) begin
         @(negedge clk);
         t++;
      end
      if (!ready) chk("R9 ready never rose", 32'd0, 32'd1);
      repeat (4) @(negedge clk);
      model(ns, win);
   endtask

   task automatic cmp_all(input string tag);
      for (int a = 0; a < 8; a++) chk(tag, {16'd0, img[a]}, {16'd0, exp_img[a]});
      chk("R6 torn count", {27'd0, torn_cnt}, exp_torn);
      chk("R8 free pointer", {27'd0, free_ptr}, exp_free);
      chk("R10 read count", reads, exp_reads);
      chk("R9 quiet after ready", late, 0);
   endtask

   initial begin
      // R2 empty log: window all ones, pointer at sector 0 slot 1
      wipe();
      run_case(4, 8, 0);
      cmp_all("R2 erased window");

      // R4 newest wins inside one sector
      wipe();
      bmem[8] = mk_hdr(5);
      bmem[9] = mk_rec(2, 16'h1111);
      bmem[10] = mk_rec(2, 16'h2222);
      bmem[11] = mk_rec(5, 16'h3333);
      run_case(4, 8, 0);
      cmp_all("R4 single sector");
      chk("R4 later record wins", {16'd0, img[2]}, 32'h2222);

      // R3 wrapped order 2,3,0 with sector 1 unused
      wipe();
      bmem[0] = mk_hdr(9);  bmem[1] = mk_rec(0, 16'hC000);
      bmem[16] = mk_hdr(7); bmem[17] = mk_rec(0, 16'hA000); bmem[18] = mk_rec(1, 16'hE000);
      bmem[24] = mk_hdr(8); bmem[25] = mk_rec(0, 16'hB000); bmem[26] = mk_rec(1, 16'hD000);
      run_case(4, 8, 0);
      cmp_all("R3 wrapped order");
      chk("R3 newest sector value", {16'd0, img[0]}, 32'hC000);
      chk("R3 middle sector value", {16'd0, img[1]}, 32'hD000);

      // R3 equal sequence numbers: lower index is older
      wipe();
      bmem[8] = mk_hdr(4);  bmem[9] = mk_rec(3, 16'h0101);
      bmem[24] = mk_hdr(4); bmem[25] = mk_rec(3, 16'h0303);
      run_case(4, 8, 0);
      cmp_all("R3 tie order");
      chk("R3 tie later sector wins", {16'd0, img[3]}, 32'h0303);

      // R6 torn records keep the previous value
      wipe();
      bmem[0] = mk_hdr(1);
      bmem[1] = mk_rec(3, 16'h1234);
      bmem[2] = mk_torn(3, 16'h9999);
      bmem[3] = mk_torn(4, 16'h7777);
      run_case(1, 8, 0);
      cmp_all("R6 torn skip");
      chk("R6 old value kept", {16'd0, img[3]}, 32'h1234);
      chk("R6 two torn", {27'd0, torn_cnt}, 32'd2);

      // R5 data after an erased slot is ignored
      wipe();
      bmem[0] = mk_hdr(1);
      bmem[1] = mk_rec(1, 16'h4444);
      bmem[3] = mk_rec(6, 16'h6666);
      run_case(2, 8, 0);
      cmp_all("R5 stop at erased");
      chk("R5 record past gap unused", {16'd0, img[6]}, 32'hFFFF);

      // R7 out-of-window address does not write
      wipe();
      bmem[0] = mk_hdr(1);
      bmem[1] = mk_rec(5, 16'h5555);
      bmem[2] = mk_rec(1, 16'h0011);
      run_case(1, 3, 0);
      cmp_all("R7 window limit");
      chk("R7 high address untouched", {16'd0, img[5]}, 32'h5A5A);

      // R1 configuration changed right after capture
      wipe();
      bmem[0] = mk_hdr(3);  bmem[1] = mk_rec(5, 16'h0555);
      bmem[16] = mk_hdr(0); bmem[17] = mk_rec(5, 16'h0AAA);
      run_case(1, 8, 1);
      cmp_all("R1 config captured once");
      chk("R1 sector 2 ignored", {16'd0, img[5]}, 32'h0555);

      // R9 full newest sector ends on a write; R8 pointer wraps
      wipe();
      bmem[0] = mk_hdr(1); bmem[1] = mk_rec(0, 16'h0101);
      bmem[8] = mk_hdr(2);
      for (int k = 1; k < 8; k++) bmem[8+k] = mk_rec(k-1, 16'h1000 + 16'(k));
      run_case(2, 8, 0);
      cmp_all("R9 full sector");
      chk("R9 ready one cycle after last write", rdy_cyc - last_we, 1);
      chk("R8 wrapped free pointer", {27'd0, free_ptr}, 32'd1);

      // R2 zero window: no writes at all
      wipe();
      bmem[0] = mk_hdr(1); bmem[1] = mk_rec(0, 16'h0F0F);
      run_case(2, 0, 0);
      cmp_all("R2 zero window");
      chk("R2 no image writes", last_we, -1);

      // R4 sweep over generated logs
      for (int n = 0; n < 60; n++) begin
         int ns, win, nrec;
         wipe();
         ns = 1 + int'(rnd() % 4);
         win = int'(rnd() % 9);
         for (int s = 0; s < 4; s++) begin
            if (rnd() % 4 != 0) begin
               bmem[s*8] = mk_hdr(int'(rnd() % 16));
               nrec = int'(rnd() % 8);
               for (int sl = 1; sl <= nrec; sl++) begin
                  if (rnd() % 8 == 0) bmem[s*8+sl] = mk_torn(int'(rnd() % 8), rnd() & 16'hFFFF);
                  else                bmem[s*8+sl] = mk_rec(int'(rnd() % 8), rnd() & 16'hFFFF);
               end
            end
         end
         run_case(ns, win, 0);
         cmp_all("R4 generated log");
      end

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule